// File: doc/BRIEF.md
# Register-Pair Signed Multiply Unit

This unit performs signed fixed-point multiplication for a processor that keeps its operands in pairs of 32-bit registers. It serves two instruction forms: a halfword form that multiplies the low 16 bits of one register by a 16-bit memory operand, and a word form that multiplies a full register by a 32-bit memory operand and can deliver a 64-bit result. A 4-bit register field names the target. The multiplicand always comes from the odd member of the pair, which is the field with its lowest bit forced to one.

The unit takes a one-cycle start pulse. It captures the opcode form, the register field and both operands in that cycle. It then runs an iterative magnitude multiplier that handles a fixed number of multiplier bits per clock. When the product is ready it raises a one-cycle done pulse. In that same cycle it presents two write-back ports, each with its own enable and register index, and a condition-code update. The update carries a value and a per-bit enable mask. Condition-code bits whose enable is low keep their previous value in the surrounding machine.

Top module: `regpair_mul`

## Requirements
- R1: Halfword form (`op_word`=0): the product of sign-extended `src_data[15:0]` and sign-extended `mem_opnd[15:0]` appears on the low port with `wr_lo_en`=1 and `wr_lo_idx` = `reg_field` with bit 0 forced to 1. `wr_hi_en` stays 0, and the upper halves of both data inputs have no effect.
- R2: Halfword form condition code: `cc_upd` = 4'b1100. In `cc_val`, bit 3 is 1 for a negative product and bit 2 is 1 for a positive product; both are 0 for a zero product.
- R3: Word form with an even `reg_field`: `wr_hi_en`=1 writes bits 63..32 of the signed 64-bit product `src_data` × `mem_opnd` to index `reg_field`. `wr_lo_en`=1 writes bits 31..0 to index `reg_field`+1.
- R4: Word form with an odd `reg_field`: only the low port writes, carrying product bits 31..0 to index `reg_field`. `wr_hi_en` stays 0.
- R5: Word form: `cc_val` bits 3 and 2 reflect the sign of the full 64-bit product, not the stored bits. For example, a product of 2^32 has zero low bits and still reads as positive.
- R6: Word form: `cc_upd` = 4'b1101. `cc_val` bit 0 is 0 when the product is representable as a 32-bit signed value and 1 when it is not. `cc_val` bit 1 is never updated.
- R7: `done` is high for exactly one cycle per accepted start, 32/`BITS_PER_STEP` clock edges after the edge that samples `start` (8 by default). The write enables and `cc_upd` are nonzero only while `done` is high.
- R8: A start pulse that arrives while a multiplication is in progress is ignored: it produces no extra done pulse and does not alter the result in progress.
- R9: The operands, the form and the register field are sampled on the accepted start edge. Later changes to those inputs do not affect the result.
- R10: After reset, `done`, both write enables and `cc_upd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| op_word | input | 1 | 1 = word form, 0 = halfword form |
| reg_field | input | 4 | Register field of the instruction |
| src_data | input | 32 | Contents of the odd pair member (field with bit 0 forced to 1) |
| mem_opnd | input | 32 | Effective operand from memory; halfword form uses bits 15..0 |
| done | output | 1 | One-cycle completion pulse |
| wr_hi_en | output | 1 | Write enable for the high product word |
| wr_hi_idx | output | 4 | Register index for the high word |
| wr_hi_data | output | 32 | Product bits 63..32 |
| wr_lo_en | output | 1 | Write enable for the low product word |
| wr_lo_idx | output | 4 | Register index for the low word |
| wr_lo_data | output | 32 | Product bits 31..0 |
| cc_val | output | 4 | Condition-code values; bit 0 = CC1 … bit 3 = CC4 |
| cc_upd | output | 4 | Per-bit condition-code update enables |

## Verification
Every result of this unit falls due in one cycle: the cycle after the eighth rising edge that follows the edge sampling `start`. The done pulse, both write ports and the condition-code update all appear together in that cycle. Each scenario task drives `start` on a falling edge and counts rising edges until `done` shows. It checks that the count equals the expected latency, then compares all outputs at the falling edge inside the done cycle. It samples once more one cycle later to confirm that the pulse and every enable have dropped. For the busy case, the task waits a fixed number of cycles after the first done and checks that no second pulse appears.

// File: rtl/regpair_mul_pkg.sv
package regpair_mul_pkg;

  typedef enum logic {
    FORM_HALF = 1'b0,
    FORM_WORD = 1'b1
  } mul_form_e;

  // Bit positions inside the condition-code vectors
  localparam int CC_FIT = 0;
  localparam int CC_OVF = 1;
  localparam int CC_POS = 2;
  localparam int CC_NEG = 3;

  localparam logic [3:0] UPD_HALF = 4'b1100;
  localparam logic [3:0] UPD_WORD = 4'b1101;

  function automatic logic [31:0] sext16(input logic [15:0] h);
    return {{16{h[15]}}, h};
  endfunction

  // Unsigned magnitude of a two's complement word (0x80000000 maps to itself)
  function automatic logic [31:0] mag32(input logic [31:0] v);
    return v[31] ? (~v + 32'd1) : v;
  endfunction

  // True when the 64-bit value equals the sign extension of its low word
  function automatic logic fits32(input logic [63:0] p);
    return p[63:32] == {32{p[31]}};
  endfunction

  // {negative, positive} classification of a 64-bit signed value
  function automatic logic [1:0] sign_class(input logic [63:0] p);
    logic nz;
    nz = |p;
    return {p[63], nz & ~p[63]};
  endfunction

endpackage

// File: rtl/mul_opnd_sel.sv
module mul_opnd_sel
  import regpair_mul_pkg::*;
(
  input  logic        word_form,
  input  logic [31:0] src_data,
  input  logic [31:0] mem_opnd,
  output logic [31:0] mag_a,
  output logic [31:0] mag_b,
  output logic        prod_neg
);

  logic [31:0] op_a;
  logic [31:0] op_b;

  always_comb begin
    if (word_form) begin
      op_a = src_data;
      op_b = mem_opnd;
    end else begin
      op_a = sext16(src_data[15:0]);
      op_b = sext16(mem_opnd[15:0]);
    end
    mag_a    = mag32(op_a);
    mag_b    = mag32(op_b);
    prod_neg = op_a[31] ^ op_b[31];
  end

endmodule

// File: rtl/mul_iter_core.sv
module mul_iter_core #(
  parameter int BITS_PER_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] mag_a,
  input  logic [31:0] mag_b,
  input  logic        neg_in,
  output logic        busy,
  output logic        done_q,
  output logic [63:0] product
);

  localparam int ITERS = 32 / BITS_PER_STEP;
  localparam int CNTW  = $clog2(ITERS) + 1;

  logic [CNTW-1:0] cnt;
  logic [31:0]     mcand;
  logic [31:0]     mplier;
  logic [63:0]     acc;
  logic            neg_q;
  logic            last_step;

  // Multiplicand times one multiplier digit, as a 64-bit sum of shifted copies
  function automatic logic [63:0] digit_pp(input logic [31:0] m,
                                           input logic [BITS_PER_STEP-1:0] d);
    logic [63:0] s;
    s = '0;
    for (int i = 0; i < BITS_PER_STEP; i++) begin
      if (d[i]) s = s + ({32'd0, m} << i);
    end
    return s;
  endfunction

  assign last_step = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      neg_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load && !busy) begin
        busy   <= 1'b1;
        cnt    <= CNTW'(ITERS - 1);
        mcand  <= mag_a;
        mplier <= mag_b;
        acc    <= '0;
        neg_q  <= neg_in;
      end else if (busy) begin
        acc    <= (acc << BITS_PER_STEP)
                  + digit_pp(mcand, mplier[31 -: BITS_PER_STEP]);
        mplier <= mplier << BITS_PER_STEP;
        if (last_step) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign product = neg_q ? (~acc + 64'd1) : acc;

  AST_STEP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1)); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (done_q && !busy)); // R7

  AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy)); // R7

endmodule

// File: rtl/mul_result_fmt.sv
module mul_result_fmt
  import regpair_mul_pkg::*;
(
  input  logic        valid,
  input  logic        word_form,
  input  logic [3:0]  reg_field,
  input  logic [63:0] product,
  output logic        wr_hi_en,
  output logic [3:0]  wr_hi_idx,
  output logic [31:0] wr_hi_data,
  output logic        wr_lo_en,
  output logic [3:0]  wr_lo_idx,
  output logic [31:0] wr_lo_data,
  output logic [3:0]  cc_val,
  output logic [3:0]  cc_upd
);

  logic [1:0] cls;

  always_comb begin
    cls        = sign_class(product);
    wr_hi_idx  = reg_field;
    wr_lo_idx  = reg_field | 4'd1;
    wr_hi_data = product[63:32];
    wr_lo_data = product[31:0];
    wr_hi_en   = valid && word_form && !reg_field[0];
    wr_lo_en   = valid;
    cc_val     = '0;
    cc_upd     = '0;
    if (valid) begin
      cc_val[CC_NEG] = cls[1];
      cc_val[CC_POS] = cls[0];
      cc_val[CC_FIT] = word_form && !fits32(product);
      cc_upd         = word_form ? UPD_WORD : UPD_HALF;
    end
  end

endmodule

// File: rtl/regpair_mul.sv
module regpair_mul
  import regpair_mul_pkg::*;
#(
  parameter int BITS_PER_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_word,
  input  logic [3:0]  reg_field,
  input  logic [31:0] src_data,
  input  logic [31:0] mem_opnd,
  output logic        done,
  output logic        wr_hi_en,
  output logic [3:0]  wr_hi_idx,
  output logic [31:0] wr_hi_data,
  output logic        wr_lo_en,
  output logic [3:0]  wr_lo_idx,
  output logic [31:0] wr_lo_data,
  output logic [3:0]  cc_val,
  output logic [3:0]  cc_upd
);

  logic [31:0] mag_a;
  logic [31:0] mag_b;
  logic        neg_in;
  logic        busy;
  logic        accept;
  logic [63:0] product;
  mul_form_e   cap_form;
  logic [3:0]  cap_rf;

  assign accept = start && !busy;

  mul_opnd_sel u_sel (
    .word_form (op_word),
    .src_data  (src_data),
    .mem_opnd  (mem_opnd),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .prod_neg  (neg_in)
  );

  mul_iter_core #(
    .BITS_PER_STEP (BITS_PER_STEP)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .mag_a   (mag_a),
    .mag_b   (mag_b),
    .neg_in  (neg_in),
    .busy    (busy),
    .done_q  (done),
    .product (product)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_form <= FORM_HALF;
      cap_rf   <= '0;
    end else if (accept) begin
      cap_form <= mul_form_e'(op_word);
      cap_rf   <= reg_field;
    end
  end

  mul_result_fmt u_fmt (
    .valid      (done),
    .word_form  (cap_form == FORM_WORD),
    .reg_field  (cap_rf),
    .product    (product),
    .wr_hi_en   (wr_hi_en),
    .wr_hi_idx  (wr_hi_idx),
    .wr_hi_data (wr_hi_data),
    .wr_lo_en   (wr_lo_en),
    .wr_lo_idx  (wr_lo_idx),
    .wr_lo_data (wr_lo_data),
    .cc_val     (cc_val),
    .cc_upd     (cc_upd)
  );

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_WRITES_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_en || wr_lo_en || (cc_upd != 4'd0)) |-> done); // R7

  AST_HI_EVEN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_en |-> (cap_form == FORM_WORD && !wr_hi_idx[0] && wr_lo_idx == wr_hi_idx + 4'd1)); // R4

  AST_CC_SIGN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(cc_val[CC_NEG] && cc_val[CC_POS])); // R5

  AST_FIT_HI_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_en && !cc_val[CC_FIT]) |-> (wr_hi_data == {32{wr_lo_data[31]}})); // R6

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cap_rf) && $stable(cap_form))); // R9

endmodule

// File: tb/test_regpair_mul.sv
module test_regpair_mul;

  localparam int STEP = 4;
  localparam int LAT  = 32 / STEP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_word = 1'b0;
  logic [3:0]  reg_field = '0;
  logic [31:0] src_data = '0;
  logic [31:0] mem_opnd = '0;
  logic        done;
  logic        wr_hi_en;
  logic [3:0]  wr_hi_idx;
  logic [31:0] wr_hi_data;
  logic        wr_lo_en;
  logic [3:0]  wr_lo_idx;
  logic [31:0] wr_lo_data;
  logic [3:0]  cc_val;
  logic [3:0]  cc_upd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  regpair_mul #(.BITS_PER_STEP(STEP)) i_regpair_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
    .reg_field(reg_field), .src_data(src_data), .mem_opnd(mem_opnd),
    .done(done), .wr_hi_en(wr_hi_en), .wr_hi_idx(wr_hi_idx),
    .wr_hi_data(wr_hi_data), .wr_lo_en(wr_lo_en), .wr_lo_idx(wr_lo_idx),
    .wr_lo_data(wr_lo_data), .cc_val(cc_val), .cc_upd(cc_upd)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Launch one operation and wait for its done pulse; returns edges counted
  task automatic launch(input logic w, input logic [3:0] rf,
                        input logic [31:0] s, input logic [31:0] m,
                        output int lat);
    @(negedge clk);
    op_word = w; reg_field = rf; src_data = s; mem_opnd = m; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input string req, input logic w, input logic [3:0] rf,
                        input logic [31:0] s, input logic [31:0] m);
    longint a, b, p;
    logic [63:0] pv;
    logic [3:0] exp_cc, exp_upd;
    int lat;
    if (w) begin
      a = longint'($signed(s)); b = longint'($signed(m));
    end else begin
      a = longint'($signed(s[15:0])); b = longint'($signed(m[15:0]));
    end
    p = a * b;
    pv = p;
    exp_cc = 4'b0000;
    if (p < 0) exp_cc[3] = 1'b1;
    if (p > 0) exp_cc[2] = 1'b1;
    if (w && (p > 64'sd2147483647 || p < -64'sd2147483648)) exp_cc[0] = 1'b1;
    exp_upd = w ? 4'b1101 : 4'b1100;
    launch(w, rf, s, m, lat);
    check("R7", {req, " latency"}, 64'(lat), 64'(LAT));
    check(req, "wr_lo_en", 64'(wr_lo_en), 64'd1);
    check(req, "wr_lo_idx", 64'(wr_lo_idx), 64'(rf | 4'd1));
    check(req, "wr_lo_data", 64'(wr_lo_data), 64'(pv[31:0]));
    check(w && !rf[0] ? "R3" : (w ? "R4" : "R1"), "wr_hi_en",
          64'(wr_hi_en), 64'(w && !rf[0]));
    if (w && !rf[0]) begin
      check("R3", "wr_hi_idx", 64'(wr_hi_idx), 64'(rf));
      check("R3", "wr_hi_data", 64'(wr_hi_data), 64'(pv[63:32]));
    end
    check(w ? "R5" : "R2", "cc_val", 64'(cc_val), 64'(exp_cc));
    check(w ? "R6" : "R2", "cc_upd", 64'(cc_upd), 64'(exp_upd));
    @(negedge clk);
    check("R7", {req, " done drops"}, 64'({done, wr_hi_en, wr_lo_en, cc_upd}), 64'd0);
  endtask

  task automatic test_reset();
    check("R10", "done after reset", 64'(done), 64'd0);
    check("R10", "enables after reset", 64'({wr_hi_en, wr_lo_en, cc_upd}), 64'd0);
  endtask

  task automatic test_busy_ignored();
    int lat, extra;
    @(negedge clk);
    op_word = 1'b1; reg_field = 4'd6; src_data = 32'd1000; mem_opnd = 32'hFFFF_FFFE;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (3) begin @(posedge clk); @(negedge clk); lat++; end
    // second start while running, with other operands (R8); inputs change (R9)
    op_word = 1'b0; reg_field = 4'd3; src_data = 32'd7; mem_opnd = 32'd9; start = 1'b1;
    @(posedge clk); @(negedge clk); lat++;
    start = 1'b0; src_data = 32'h5555_5555; mem_opnd = 32'h1234_5678;
    while (!done && lat < 100) begin @(posedge clk); @(negedge clk); lat++; end
    check("R8", "latency of first op", 64'(lat), 64'(LAT));
    check("R9", "wr_hi_idx", 64'(wr_hi_idx), 64'd6);
    check("R9", "wr_lo_data", 64'(wr_lo_data), 64'hFFFF_F830);
    check("R9", "wr_hi_data", 64'(wr_hi_data), 64'hFFFF_FFFF);
    extra = 0;
    repeat (2 * LAT) begin
      @(posedge clk); @(negedge clk);
      if (done) extra++;
    end
    check("R8", "extra done pulses", 64'(extra), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_op("R1", 1'b0, 4'd5, 32'h0000_000A, 32'h0000_FFFF);   // example, odd field
    run_op("R1", 1'b0, 4'd4, 32'h1234_0003, 32'hABCD_0007);   // upper halves ignored
    run_op("R2", 1'b0, 4'd9, 32'h0000_0000, 32'h0000_8000);   // zero product
    run_op("R2", 1'b0, 4'd0, 32'h0000_8000, 32'h0000_8000);   // -32768 squared
    run_op("R3", 1'b1, 4'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF);   // large, not fitting
    run_op("R4", 1'b1, 4'd7, 32'hFFFF_FFFD, 32'h0000_0005);   // odd field, -15
    run_op("R5", 1'b1, 4'd8, 32'h0001_0000, 32'h0001_0000);   // 2^32, low word zero
    run_op("R6", 1'b1, 4'd10, 32'h8000_0000, 32'h0000_0001);  // -2^31 fits
    run_op("R6", 1'b1, 4'd12, 32'h8000_0000, 32'hFFFF_FFFF);  // +2^31 does not fit
    run_op("R5", 1'b1, 4'd14, 32'h0000_0000, 32'hDEAD_BEEF);  // zero word product
    run_op("R3", 1'b1, 4'd0, 32'hFFFF_0000, 32'h0001_2345);   // negative, even field
    test_busy_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule